// File: doc/BRIEF.md
# Word and Frame Sync Generator

This block sits beside a synchronous serial port and turns a stream of bit clock strobes into word and frame timing. A bit counter marks the end of each word, whose length is picked from four sizes by a 2-bit code. A word counter marks the end of each frame, whose size is set from 1 to 32 words by a 5-bit divide field. From that position the block produces a frame sync that can last one bit or one whole word. Both forms start on the first bit of the frame.

The sync pin works in one of two directions. In output mode the block drives the generated sync onto the pin and raises the pin's output enable. In input mode the enable is low and the block watches the pin instead. An inactive-to-active change seen on a strobe marks that strobe as the first bit of a frame and restarts the counters from there. An invert control flips the active sense of the sync in both directions. A control clear, and the block reset, returns the counters to the first bit of a frame.

Top module: `wfsync_gen`

## Requirements
- R1: The word length code gives the bits per word: 2'b00 gives 8, 2'b01 gives 10, 2'b10 gives 12 and 2'b11 gives 16. `word_done` pulses on every strobe that completes a word, which is the strobe whose index since the last clear satisfies k mod L = L-1.
- R2: `word_done` and `frame_start` are high only in a cycle where `bit_stb` is high, for that one cycle. They are never high together.
- R3: In output mode, a divide field of M gives M+1 words per frame. `frame_start` is high on strobe k when k mod ((M+1)*L) = 0.
- R4: In output mode, `sync_oe` is 1. The sync becomes active in the cycle after a `frame_start` strobe and holds its level until the next strobe.
- R5: With `sync_len_word` = 0 the sync is active for one bit period. With `sync_len_word` = 1 it stays active for all L bit periods of the first word of the frame.
- R6: With `sync_inv` = 1 the active level is low, both on the driven pin and on the received pin. With `sync_inv` = 0 the active level is high.
- R7: While `ctl_clr` is high, no strobe is issued. After a clear the sync is inactive, and the next strobe is the first bit of a frame.
- R8: In input mode, `sync_oe` is 0. A strobe at which the received sync is active, when it was inactive at the previous strobe, gives `frame_start` on that strobe. That strobe counts as bit 0, so `word_done` follows L-1 strobes later.
- R9: In input mode, `frame_start` is issued only for a received edge. It is not issued when the pin stays at one level, whatever the free-running count does.
- R10: After the block reset, the strobe outputs are low and the sync pin is inactive. The first strobe is a frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe per serial bit |
| wlen_code | input | 2 | Word length select (8/10/12/16) |
| frame_div | input | 5 | Words per frame minus one |
| sync_drive | input | 1 | 1: drive sync onto pin, 0: receive it |
| sync_inv | input | 1 | Invert sync active level |
| sync_len_word | input | 1 | 1: sync lasts one word, 0: one bit |
| ctl_clr | input | 1 | Control clear of counters and sync |
| sync_pin_in | input | 1 | Sync pin input value |
| word_done | output | 1 | Strobe on the last bit of each word |
| frame_start | output | 1 | Strobe on the first bit of each frame |
| sync_pin_out | output | 1 | Sync pin drive value |
| sync_oe | output | 1 | Sync pin output enable |

## Verification
Several properties are checked on every cycle. The bit index returns to zero after a word end, and the word index wraps after the last word of a frame. A clear and a received restart each leave the counters at a known position, a frame start always arms the internal sync, and the two strobes never coincide. Other behaviour is shown only by the bench's scenarios. These are the actual word and frame periods for each length code and divide value, the sync width and polarity seen at the pin, and the input-mode rule that a steady pin never starts a frame.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
    localparam int BIT_CW  = 4;
    localparam int WORD_CW = 5;

    typedef enum logic [1:0] {
        WL_8  = 2'b00,
        WL_10 = 2'b01,
        WL_12 = 2'b10,
        WL_16 = 2'b11
    } wlen_e;

    typedef struct packed {
        logic [BIT_CW-1:0]  bit_idx;
        logic [WORD_CW-1:0] word_idx;
    } slot_t;

    function automatic logic [BIT_CW-1:0] last_bit_of(input wlen_e wl);
        case (wl)
            WL_8:    last_bit_of = BIT_CW'(7);
            WL_10:   last_bit_of = BIT_CW'(9);
            WL_12:   last_bit_of = BIT_CW'(11);
            default: last_bit_of = BIT_CW'(15);
        endcase
    endfunction
endpackage

// File: rtl/wfs_bit_cnt.sv
module wfs_bit_cnt #(
    parameter int CW = wfs_pkg::BIT_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          stb,
    input  logic          restart,
    input  logic [CW-1:0] last_idx,
    output logic [CW-1:0] bit_idx,
    output logic          word_end
);
    logic at_last;

    assign at_last  = (bit_idx >= last_idx);
    assign word_end = stb && !clr && !restart && at_last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bit_idx <= '0;
        end else if (restart) begin
            bit_idx <= CW'(1);
        end else if (stb) begin
            bit_idx <= at_last ? '0 : bit_idx + CW'(1);
        end
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        word_end |=> (bit_idx == '0));
    assert_clear_bits_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bit_idx == '0));
    assert_restart_bits_R8: assert property (@(posedge clk) disable iff (rst)
        (restart && !clr) |=> (bit_idx == CW'(1)));
endmodule

// File: rtl/wfs_word_cnt.sv
module wfs_word_cnt #(
    parameter int CW = wfs_pkg::WORD_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          restart,
    input  logic          word_end,
    input  logic [CW-1:0] div,
    output logic [CW-1:0] word_idx
);
    always_ff @(posedge clk) begin
        if (rst || clr || restart) begin
            word_idx <= '0;
        end else if (word_end) begin
            word_idx <= (word_idx >= div) ? '0 : word_idx + CW'(1);
        end
    end

    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (word_end && word_idx >= div) |=> (word_idx == '0));
    assert_clear_words_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (word_idx == '0));
endmodule

// File: rtl/wfs_sync_unit.sv
module wfs_sync_unit
    import wfs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  stb,
    input  logic  drive,
    input  logic  inv,
    input  logic  len_word,
    input  slot_t here,
    input  logic  pin_in,
    output logic  restart,
    output logic  frame_start,
    output logic  pin_out
);
    logic  rx_act;
    logic  rx_prev;
    logic  sync_act;
    slot_t pos;
    logic  in_window;

    assign rx_act  = pin_in ^ inv;
    assign restart = stb && !clr && !drive && rx_act && !rx_prev;

    always_comb begin
        pos = here;
        if (restart) begin
            pos = '0;
        end
    end

    assign in_window   = (pos.word_idx == '0) && (len_word || pos.bit_idx == '0);
    assign frame_start = drive ? (stb && !clr && pos == '0) : restart;
    assign pin_out     = sync_act ^ inv;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rx_prev  <= 1'b0;
            sync_act <= 1'b0;
        end else if (stb) begin
            rx_prev  <= rx_act;
            sync_act <= in_window;
        end
    end

    assert_sync_arms_R4: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> sync_act);
    assert_clear_sync_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> !sync_act);
    assert_rx_edge_only_R9: assert property (@(posedge clk) disable iff (rst)
        (!drive && frame_start) |-> (rx_act && !rx_prev));
endmodule

// File: rtl/wfsync_gen.sv
module wfsync_gen
    import wfs_pkg::*;
#(
    parameter int BCW = BIT_CW,
    parameter int WCW = WORD_CW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_stb,
    input  logic [1:0]     wlen_code,
    input  logic [WCW-1:0] frame_div,
    input  logic           sync_drive,
    input  logic           sync_inv,
    input  logic           sync_len_word,
    input  logic           ctl_clr,
    input  logic           sync_pin_in,
    output logic           word_done,
    output logic           frame_start,
    output logic           sync_pin_out,
    output logic           sync_oe
);
    logic [BCW-1:0] last_idx;
    logic [BCW-1:0] bit_idx;
    logic [WCW-1:0] word_idx;
    logic           restart;
    slot_t          here;

    assign last_idx = BCW'(last_bit_of(wlen_e'(wlen_code)));
    assign here     = '{bit_idx: BIT_CW'(bit_idx), word_idx: WORD_CW'(word_idx)};
    assign sync_oe  = sync_drive;

    wfs_bit_cnt #(.CW(BCW)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl_clr),
        .stb      (bit_stb),
        .restart  (restart),
        .last_idx (last_idx),
        .bit_idx  (bit_idx),
        .word_end (word_done)
    );

    wfs_word_cnt #(.CW(WCW)) u_words (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl_clr),
        .restart  (restart),
        .word_end (word_done),
        .div      (frame_div),
        .word_idx (word_idx)
    );

    wfs_sync_unit u_sync (
        .clk         (clk),
        .rst         (rst),
        .clr         (ctl_clr),
        .stb         (bit_stb),
        .drive       (sync_drive),
        .inv         (sync_inv),
        .len_word    (sync_len_word),
        .here        (here),
        .pin_in      (sync_pin_in),
        .restart     (restart),
        .frame_start (frame_start),
        .pin_out     (sync_pin_out)
    );

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_done, frame_start}));
    assert_strobe_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (word_done || frame_start) |-> bit_stb);
endmodule

// File: tb/wfsync_gen_bench.sv
module wfsync_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic [1:0] wlen_code = 2'b00;
    logic [4:0] frame_div = 5'd0;
    logic       sync_drive = 1'b1;
    logic       sync_inv = 1'b0;
    logic       sync_len_word = 1'b0;
    logic       ctl_clr = 1'b0;
    logic       sync_pin_in = 1'b0;
    logic       word_done, frame_start, sync_pin_out, sync_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wfsync_gen u_wfsync_gen (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .wlen_code(wlen_code),
        .frame_div(frame_div), .sync_drive(sync_drive), .sync_inv(sync_inv),
        .sync_len_word(sync_len_word), .ctl_clr(ctl_clr), .sync_pin_in(sync_pin_in),
        .word_done(word_done), .frame_start(frame_start),
        .sync_pin_out(sync_pin_out), .sync_oe(sync_oe)
    );

    // vector fields: {wlen_code[1:0], frame_div[4:0], sync_len_word, sync_inv}
    localparam logic [8:0] VECS [6] = '{
        {2'b00, 5'd0,  1'b0, 1'b0},
        {2'b01, 5'd2,  1'b0, 1'b0},
        {2'b10, 5'd1,  1'b1, 1'b0},
        {2'b11, 5'd3,  1'b1, 1'b1},
        {2'b00, 5'd31, 1'b0, 1'b1},
        {2'b11, 5'd0,  1'b1, 1'b0}
    };

    function automatic int wlen_bits(input logic [1:0] c);
        case (c)
            2'b00:   return 8;
            2'b01:   return 10;
            2'b10:   return 12;
            default: return 16;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic s, output logic wd, output logic fs, output logic sp);
        @(negedge clk);
        bit_stb = s;
        #2;
        wd = word_done;
        fs = frame_start;
        @(posedge clk);
        #1;
        sp = sync_pin_out;
        bit_stb = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        ctl_clr = 1'b1;
        @(posedge clk);
        #1;
        ctl_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic wd, fs, sp;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(word_done == 1'b0 && frame_start == 1'b0, "R10 strobes idle", {word_done, frame_start}, 0);
        check(sync_pin_out == 1'b0, "R10 sync inactive", sync_pin_out, 0);
        check(sync_oe == 1'b1, "R4 output enable", sync_oe, 1);
        step(1'b1, wd, fs, sp);
        check(fs == 1'b1, "R10 first strobe frame start", fs, 1);

        // table walk: R1, R3, R5, R6
        for (int v = 0; v < 6; v++) begin
            int wl, flen, swin, bad_wd, bad_fs, bad_sp, fk;
            logic inv_v;
            wlen_code     = VECS[v][8:7];
            frame_div     = VECS[v][6:2];
            sync_len_word = VECS[v][1];
            inv_v         = VECS[v][0];
            sync_inv      = inv_v;
            wl   = wlen_bits(VECS[v][8:7]);
            flen = (int'(VECS[v][6:2]) + 1) * wl;
            swin = VECS[v][1] ? wl : 1;
            bad_wd = 0; bad_fs = 0; bad_sp = 0; fk = -1;
            pulse_clear();
            for (int k = 0; k < 2 * flen + 3; k++) begin
                logic ewd, efs, esp;
                step(1'b1, wd, fs, sp);
                ewd = ((k % wl) == wl - 1);
                efs = ((k % flen) == 0);
                esp = ((k % flen) < swin) ^ inv_v;
                if (wd !== ewd) begin bad_wd++; if (fk < 0) fk = k; end
                if (fs !== efs) bad_fs++;
                if (sp !== esp) bad_sp++;
            end
            check(bad_wd == 0, $sformatf("R1 word period vec %0d", v), bad_wd, 0);
            check(bad_fs == 0, $sformatf("R3 frame period vec %0d", v), bad_fs, 0);
            check(bad_sp == 0, $sformatf("R5 R6 sync shape vec %0d", v), bad_sp, 0);
        end

        // R2: no word_done without a strobe, even at the last bit
        sync_inv = 1'b0; wlen_code = 2'b00; frame_div = 5'd3; sync_len_word = 1'b0;
        pulse_clear();
        for (int k = 0; k < 7; k++) step(1'b1, wd, fs, sp);
        step(1'b0, wd, fs, sp);
        check(wd == 1'b0 && fs == 1'b0, "R2 idle cycle", {wd, fs}, 0);
        step(1'b1, wd, fs, sp);
        check(wd == 1'b1, "R2 word end on strobe", wd, 1);

        // R7: mid-frame clear restarts frame
        for (int k = 0; k < 5; k++) step(1'b1, wd, fs, sp);
        @(negedge clk);
        ctl_clr = 1'b1;
        bit_stb = 1'b1;
        #2;
        check(word_done == 1'b0 && frame_start == 1'b0, "R7 no strobe during clear", {word_done, frame_start}, 0);
        @(posedge clk);
        #1;
        ctl_clr = 1'b0;
        bit_stb = 1'b0;
        check(sync_pin_out == 1'b0, "R7 sync inactive after clear", sync_pin_out, 0);
        step(1'b1, wd, fs, sp);
        check(fs == 1'b1 && sp == 1'b1, "R7 frame start after clear", {fs, sp}, 3);

        // R8, R9: input mode, active high
        sync_drive = 1'b0; frame_div = 5'd0; sync_pin_in = 1'b0;
        pulse_clear();
        #1;
        check(sync_oe == 1'b0, "R8 output enable off", sync_oe, 0);
        begin
            int nfs = 0;
            for (int k = 0; k < 40; k++) begin step(1'b1, wd, fs, sp); if (fs) nfs++; end
            check(nfs == 0, "R9 no frame without edge (low)", nfs, 0);
        end
        step(1'b1, wd, fs, sp);
        sync_pin_in = 1'b1;
        step(1'b1, wd, fs, sp);
        check(fs == 1'b1 && wd == 1'b0, "R8 edge gives frame start", {fs, wd}, 2);
        begin
            int nwd = 0;
            for (int k = 0; k < 6; k++) begin step(1'b1, wd, fs, sp); if (wd) nwd++; end
            check(nwd == 0, "R8 no early word end", nwd, 0);
        end
        step(1'b1, wd, fs, sp);
        check(wd == 1'b1, "R8 word end after restart", wd, 1);
        begin
            int nfs = 0;
            for (int k = 0; k < 20; k++) begin step(1'b1, wd, fs, sp); if (fs) nfs++; end
            check(nfs == 0, "R9 no frame with pin held high", nfs, 0);
        end

        // R6: input mode, inverted
        sync_inv = 1'b1; sync_pin_in = 1'b1;
        pulse_clear();
        begin
            int nfs = 0;
            for (int k = 0; k < 3; k++) begin step(1'b1, wd, fs, sp); if (fs) nfs++; end
            check(nfs == 0, "R6 inverted idle high", nfs, 0);
        end
        sync_pin_in = 1'b0;
        step(1'b1, wd, fs, sp);
        check(fs == 1'b1, "R6 inverted falling edge", fs, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule